// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This block turns a small set of programmable predication entries into per-register predicate masks. Each entry binds one source or destination register number, in either the integer or the floating-point register class, to an integer register that holds the real element mask. The entry also carries an invert option and a zeroing option. The unit keeps up to sixteen entries. It expands them into two 32-slot tables, one per register class, and rebuilds the tables every cycle from the stored entries.

An issue stage presents a request with a class bit and a register number. The unit looks up the slot for that class. For an enabled slot it reads the named integer register through a read port with a one-cycle latency, and it complements the value when invert is set. For an empty slot it returns a mask of all ones. The response arrives one cycle after the request and carries the mask and the zeroing flag. The mask always comes from the integer register file, whichever class is asked for.

Top module: `pred_mask_lookup`

## Requirements
- R1: After reset no entry is active, `dup_err` and `resp_valid` are 0, and every lookup returns an all-ones mask.
- R2: A lookup that hits a disabled slot returns `resp_mask` all ones and `resp_zero` 0, and does not assert `rf_rd_en`.
- R3: A lookup that hits an enabled slot asserts `rf_rd_en` in the request cycle, with `rf_rd_addr` equal to the entry's mask register. Without invert, `resp_mask` equals the data returned on the next cycle.
- R4: When the entry's invert bit is 1, `resp_mask` is the bitwise complement of the returned register data.
- R5: For an enabled slot, `resp_zero` equals the entry's zeroing bit.
- R6: A request with `req_fp`=1 consults only entries with `cfg_fp`=1. A request with `req_fp`=0 consults only entries with `cfg_fp`=0. Both classes read the mask from the same integer read port.
- R7: When two active entries share the same class and key, the entry with the higher index decides the slot, and `dup_err` is 1 while the conflict remains.
- R8: Writing an entry with `cfg_active`=0 removes its binding. Its slot becomes disabled, or falls back to a lower-indexed entry with the same class and key.
- R9: `resp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1, and is 0 otherwise.
- R10: An entry written at clock edge N affects requests sampled at edge N+2 or later. A request sampled at edge N+1 still sees the previous table.
- R11: An entry whose bank bit is 1 is reserved and has no effect on any slot or on `dup_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 4 | Entry index written |
| cfg_active | input | 1 | Entry holds a binding |
| cfg_fp | input | 1 | Entry class: 1 floating-point, 0 integer |
| cfg_key | input | 5 | Register number the entry binds |
| cfg_preg | input | 5 | Integer register holding the mask |
| cfg_inv | input | 1 | Complement the mask |
| cfg_zero | input | 1 | Zeroing flag for inactive elements |
| cfg_bank | input | 1 | Bank select, 1 reserved (entry ignored) |
| req_valid | input | 1 | Lookup request |
| req_fp | input | 1 | Request class: 1 floating-point |
| req_reg | input | 5 | Register number looked up |
| rf_rd_en | output | 1 | Integer register file read strobe |
| rf_rd_addr | output | 5 | Integer register file read address |
| rf_rd_data | input | 32 | Read data, one cycle after the strobe |
| resp_valid | output | 1 | Response strobe |
| resp_mask | output | 32 | Effective predicate mask |
| resp_zero | output | 1 | Zeroing flag, 0 for a disabled slot |
| dup_err | output | 1 | Duplicate class-and-key among active entries |

## Verification
A wrong table slot shows on the next lookup of that class and register. The symptom is a missing or misaddressed read strobe in the request cycle, or a wrong mask or zeroing flag one cycle later. A fault in the rebuild of the tables shows two edges after the entry write, either as a stale binding or as a wrong `dup_err`. A fault in the response pipeline shows as a response strobe that is not exactly one cycle after the request. Sweeping all 64 class-and-register pairs after each change to the entries exposes any corrupted slot within one sweep.

// File: rtl/pml_pkg.sv
package pml_pkg;
    localparam int IDX_W     = 5;
    localparam int NUM_SLOTS = 1 << IDX_W;

    typedef struct packed {
        logic             active;
        logic             fp;
        logic [IDX_W-1:0] key;
        logic [IDX_W-1:0] preg;
        logic             inv;
        logic             zero;
        logic             bank;
    } entry_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] preg;
        logic             inv;
        logic             zero;
    } slot_t;
endpackage

// File: rtl/pml_entry_store.sv
module pml_entry_store
    import pml_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ENT_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ENT_W-1:0]             wr_idx,
    input  entry_t                       wr_entry,
    output entry_t [NUM_ENTRIES-1:0]     entries_o
);
    typedef struct packed {
        entry_t [NUM_ENTRIES-1:0] ent;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_idx) < NUM_ENTRIES)) begin
            st_d.ent[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign entries_o = st_q.ent;
endmodule

// File: rtl/pml_table_expand.sv
module pml_table_expand
    import pml_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  entry_t [NUM_ENTRIES-1:0]           entries_i,
    output slot_t  [1:0][NUM_SLOTS-1:0]        tbl_o,
    output logic                               dup_o
);
    typedef struct packed {
        slot_t [1:0][NUM_SLOTS-1:0] tbl;
        logic                       dup;
    } exp_t;

    exp_t st_d, st_q;

    // Clear both tables, then fill in ascending entry order so the
    // highest-indexed entry for a class/key pair is the one kept.
    always_comb begin
        st_d = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (entries_i[e].active && !entries_i[e].bank) begin
                if (st_d.tbl[entries_i[e].fp][entries_i[e].key].en) begin
                    st_d.dup = 1'b1;
                end
                st_d.tbl[entries_i[e].fp][entries_i[e].key] = '{
                    en:   1'b1,
                    preg: entries_i[e].preg,
                    inv:  entries_i[e].inv,
                    zero: entries_i[e].zero
                };
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbl_o = st_q.tbl;
    assign dup_o = st_q.dup;
endmodule

// File: rtl/pml_lookup.sv
module pml_lookup
    import pml_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  slot_t [1:0][NUM_SLOTS-1:0]  tbl_i,
    input  logic                        req_valid,
    input  logic                        req_fp,
    input  logic [IDX_W-1:0]            req_reg,
    output logic                        rf_rd_en,
    output logic [IDX_W-1:0]            rf_rd_addr,
    input  logic [MASK_W-1:0]           rf_rd_data,
    output logic                        resp_valid,
    output logic [MASK_W-1:0]           resp_mask,
    output logic                        resp_zero
);
    typedef struct packed {
        logic valid;
        logic en;
        logic inv;
        logic zero;
    } pipe_t;

    pipe_t st_d, st_q;
    slot_t sel;

    always_comb begin
        sel        = tbl_i[req_fp][req_reg];
        rf_rd_en   = req_valid && sel.en;
        rf_rd_addr = sel.preg;
        st_d       = '{valid: req_valid, en: sel.en, inv: sel.inv, zero: sel.zero};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        resp_valid = st_q.valid;
        if (!st_q.en) begin
            resp_mask = '1;
            resp_zero = 1'b0;
        end else begin
            resp_mask = st_q.inv ? ~rf_rd_data : rf_rd_data;
            resp_zero = st_q.zero;
        end
    end
endmodule

// File: rtl/pred_mask_lookup.sv
module pred_mask_lookup
    import pml_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int MASK_W      = 32,
    parameter int ENT_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ENT_W-1:0]  cfg_idx,
    input  logic              cfg_active,
    input  logic              cfg_fp,
    input  logic [IDX_W-1:0]  cfg_key,
    input  logic [IDX_W-1:0]  cfg_preg,
    input  logic              cfg_inv,
    input  logic              cfg_zero,
    input  logic              cfg_bank,
    input  logic              req_valid,
    input  logic              req_fp,
    input  logic [IDX_W-1:0]  req_reg,
    output logic              rf_rd_en,
    output logic [IDX_W-1:0]  rf_rd_addr,
    input  logic [MASK_W-1:0] rf_rd_data,
    output logic              resp_valid,
    output logic [MASK_W-1:0] resp_mask,
    output logic              resp_zero,
    output logic              dup_err
);
    entry_t                     wr_entry;
    entry_t [NUM_ENTRIES-1:0]   entries;
    slot_t  [1:0][NUM_SLOTS-1:0] tbl;

    assign wr_entry = '{
        active: cfg_active, fp: cfg_fp, key: cfg_key, preg: cfg_preg,
        inv: cfg_inv, zero: cfg_zero, bank: cfg_bank
    };

    pml_entry_store #(.NUM_ENTRIES(NUM_ENTRIES), .ENT_W(ENT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_entry  (wr_entry),
        .entries_o (entries)
    );

    pml_table_expand #(.NUM_ENTRIES(NUM_ENTRIES)) u_expand (
        .clk       (clk),
        .rst_n     (rst_n),
        .entries_i (entries),
        .tbl_o     (tbl),
        .dup_o     (dup_err)
    );

    pml_lookup #(.MASK_W(MASK_W)) u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .tbl_i      (tbl),
        .req_valid  (req_valid),
        .req_fp     (req_fp),
        .req_reg    (req_reg),
        .rf_rd_en   (rf_rd_en),
        .rf_rd_addr (rf_rd_addr),
        .rf_rd_data (rf_rd_data),
        .resp_valid (resp_valid),
        .resp_mask  (resp_mask),
        .resp_zero  (resp_zero)
    );
endmodule

// File: rtl/pml_checker.sv
module pml_checker #(
    parameter int MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rf_rd_en,
    input logic [MASK_W-1:0] rf_rd_data,
    input logic              resp_valid,
    input logic [MASK_W-1:0] resp_mask,
    input logic              resp_zero
);
    p_resp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_no_resp_without_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    p_read_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> req_valid);

    p_disabled_all_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rf_rd_en) |=> (resp_mask == {MASK_W{1'b1}}));

    p_disabled_no_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rf_rd_en) |=> !resp_zero);

    p_mask_from_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |=> ((resp_mask == rf_rd_data) || (resp_mask == ~rf_rd_data)));
endmodule

bind pred_mask_lookup pml_checker #(.MASK_W(MASK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rf_rd_en   (rf_rd_en),
    .rf_rd_data (rf_rd_data),
    .resp_valid (resp_valid),
    .resp_mask  (resp_mask),
    .resp_zero  (resp_zero)
);

// File: tb/pred_mask_lookup_tb.sv
`timescale 1ns/1ps
module pred_mask_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_active = 1'b0, cfg_fp = 1'b0, cfg_inv = 1'b0, cfg_zero = 1'b0, cfg_bank = 1'b0;
    logic [4:0]  cfg_key = '0, cfg_preg = '0;
    logic        req_valid = 1'b0, req_fp = 1'b0;
    logic [4:0]  req_reg = '0;
    logic        rf_rd_en;
    logic [4:0]  rf_rd_addr;
    logic [31:0] rf_rd_data = '0;
    logic        resp_valid, resp_zero, dup_err;
    logic [31:0] resp_mask;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the entries
    bit       m_act [16];
    bit       m_fp [16];
    bit       m_inv [16];
    bit       m_zero [16];
    bit       m_bank [16];
    bit [4:0] m_key [16];
    bit [4:0] m_preg [16];

    always #5 clk = ~clk;

    pred_mask_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_active(cfg_active), .cfg_fp(cfg_fp), .cfg_key(cfg_key),
        .cfg_preg(cfg_preg), .cfg_inv(cfg_inv), .cfg_zero(cfg_zero),
        .cfg_bank(cfg_bank), .req_valid(req_valid), .req_fp(req_fp),
        .req_reg(req_reg), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr),
        .rf_rd_data(rf_rd_data), .resp_valid(resp_valid),
        .resp_mask(resp_mask), .resp_zero(resp_zero), .dup_err(dup_err)
    );

    function automatic logic [31:0] rfv(input logic [4:0] a);
        return 32'h9E37_79B9 * (32'(a) + 32'd1);
    endfunction

    // integer register file model, one-cycle read latency
    always @(posedge clk) if (rf_rd_en) rf_rd_data <= rfv(rf_rd_addr);

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        summary();
    end

    // write one entry at a negedge, then let the table settle (R10)
    task automatic wr(input int idx, input bit act, input bit fp, input int key,
                      input int preg, input bit inv, input bit zero, input bit bank);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_active = act; cfg_fp = fp;
        cfg_key = 5'(key); cfg_preg = 5'(preg); cfg_inv = inv; cfg_zero = zero; cfg_bank = bank;
        m_act[idx] = act; m_fp[idx] = fp; m_key[idx] = 5'(key); m_preg[idx] = 5'(preg);
        m_inv[idx] = inv; m_zero[idx] = zero; m_bank[idx] = bank;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic look(input bit fp, input int r);
        int hit = -1;
        logic [31:0] exp_mask;
        bit exp_zero;
        for (int e = 0; e < 16; e++)
            if (m_act[e] && !m_bank[e] && m_fp[e] == fp && m_key[e] == 5'(r)) hit = e;
        req_valid = 1'b1; req_fp = fp; req_reg = 5'(r);
        #1;
        if (hit < 0) begin
            chk(rf_rd_en == 1'b0, "R2 no read on disabled slot (R6 class)", 32'(rf_rd_en), 32'd0);
            exp_mask = '1; exp_zero = 1'b0;
        end else begin
            chk(rf_rd_en == 1'b1, "R3 read strobe (R6 class)", 32'(rf_rd_en), 32'd1);
            chk(rf_rd_addr == m_preg[hit], "R3 read address (R7 winner)", 32'(rf_rd_addr), 32'(m_preg[hit]));
            exp_mask = m_inv[hit] ? ~rfv(m_preg[hit]) : rfv(m_preg[hit]);
            exp_zero = m_zero[hit];
        end
        @(negedge clk);
        chk(resp_valid == 1'b1, "R9 response one cycle after request", 32'(resp_valid), 32'd1);
        chk(resp_mask == exp_mask, (hit < 0) ? "R2 all-ones mask" : "R3/R4 mask", resp_mask, exp_mask);
        chk(resp_zero == exp_zero, "R5 zeroing flag", 32'(resp_zero), 32'(exp_zero));
        req_valid = 1'b0;
    endtask

    task automatic sweep();
        bit exp_dup = 1'b0;
        for (int a = 0; a < 16; a++)
            for (int b = a + 1; b < 16; b++)
                if (m_act[a] && m_act[b] && !m_bank[a] && !m_bank[b] &&
                    m_fp[a] == m_fp[b] && m_key[a] == m_key[b]) exp_dup = 1'b1;
        chk(dup_err == exp_dup, "R7/R11 duplicate flag", 32'(dup_err), 32'(exp_dup));
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 32; r++) look(f[0], r);
        #1;
        chk(resp_valid == 1'b1, "R9 last response held", 32'(resp_valid), 32'd1);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9 no response when idle", 32'(resp_valid), 32'd0);
    endtask

    initial begin
        for (int e = 0; e < 16; e++) begin
            m_act[e] = 0; m_fp[e] = 0; m_inv[e] = 0; m_zero[e] = 0; m_bank[e] = 0;
            m_key[e] = '0; m_preg[e] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(dup_err == 1'b0, "R1 dup_err after reset", 32'(dup_err), 32'd0);
        chk(resp_valid == 1'b0, "R1 resp_valid after reset", 32'(resp_valid), 32'd0);
        chk(rf_rd_en == 1'b0, "R1 no read after reset", 32'(rf_rd_en), 32'd0);
        sweep(); // R1: empty tables give all ones everywhere

        // distinct bindings in both classes, one reserved-bank entry (R11)
        wr(0, 1, 0, 3, 7, 0, 1, 0);
        wr(1, 1, 1, 3, 9, 1, 0, 0);   // R6 same key, other class
        wr(2, 1, 0, 31, 0, 1, 1, 0);  // R4 inverted
        wr(5, 1, 1, 0, 31, 0, 1, 0);
        wr(7, 1, 0, 10, 4, 0, 1, 1);  // R11 ignored
        wr(8, 1, 0, 3, 2, 0, 0, 1);   // R11 no duplicate from a reserved entry
        sweep();

        // R7: duplicate, higher index wins
        wr(9, 1, 0, 3, 12, 1, 0, 0);
        sweep();

        // R8: remove winner, then remove the remaining binding
        wr(9, 0, 0, 3, 12, 1, 0, 0);
        sweep();
        wr(0, 0, 0, 3, 7, 0, 1, 0);
        sweep();

        // R10: write at edge N, request sampled at N+1 sees old, at N+2 sees new
        cfg_we = 1'b1; cfg_idx = 4'd3; cfg_active = 1'b1; cfg_fp = 1'b0;
        cfg_key = 5'd20; cfg_preg = 5'd5; cfg_inv = 1'b0; cfg_zero = 1'b1; cfg_bank = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b1; req_fp = 1'b0; req_reg = 5'd20;
        @(negedge clk);
        chk(resp_mask == 32'hFFFF_FFFF, "R10 old table one cycle after write", resp_mask, 32'hFFFF_FFFF);
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_mask == rfv(5'd5), "R10 new table two cycles after write", resp_mask, rfv(5'd5));
        chk(resp_zero == 1'b1, "R10 new zeroing flag", 32'(resp_zero), 32'd1);
        @(negedge clk);
        summary();
    end
endmodule